// File: doc/BRIEF.md
# Order-Preserving Input-Stage Dispatcher

This block is the first-stage dispatcher of a three-stage switching fabric whose modules all buffer cells. Each local queue is identified by its local input port, its destination port and its traffic class. Every time slot, the block decides which center module, if any, receives the head cell of each queue. It may send at most one cell over each center-module link.

Each center module holds exactly one cell slot per (destination, class) pair for this input module. The dispatcher keeps its own copy of whether each slot is free. It learns that a slot has been freed only when that center module reports a departure. A queue may have at most one cell anywhere in the center stage. Cells of one flow therefore cannot overtake each other, even though several center modules can carry them. Queues from different local ports that share a destination and class may still fill different center modules at once.

The block also turns one-based global port numbers into module and local-port indices. The payload store sits outside the block. It presents one occupancy bit per queue and pops a cell when that cell is dispatched.

Top module: `cfd_dispatcher`

## Requirements
- R1: From a one-based global input number s and destination d, one cycle later the block outputs the input module (s-1)/NLOC+1, the local port ((s-1) mod NLOC)+1 and the output module (d-1)/NLOC+1, using integer division.
- R2: While reset is high, and in the first cycle after it, no dispatch is signalled. Reset leaves every center slot free and every queue not outstanding.
- R3: A queue is dispatched on link g only if three conditions hold: its occupancy bit is set, it is not outstanding, and center slot (g, dest, class) is free. The dispatch appears on the link outputs in the cycle after the decision. The queue index is (port*NPORT+dest)*NCLS+class.
- R4: In one cycle each link carries at most one cell, and no queue is dispatched on two links.
- R5: A dispatched queue becomes outstanding and is not dispatched again until the slot holding its cell reports a departure. It may be dispatched again in the cycle after that report takes effect.
- R6: Queues of different local ports with the same destination and class may be dispatched in the same cycle to different center modules.
- R7: On any link, an eligible queue of a higher class number is chosen before any queue of a lower class number.
- R8: For each class, link g searches combined indices j=port*NPORT+dest starting from (t + g*(NLOC*NPORT/NCM)) mod (NLOC*NPORT), where t counts cycles since reset was released and starts at 0. Link 0 chooses first, and later links skip queues already taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_occ | input | NQ | Head-cell present, one bit per queue |
| dep_valid | input | NCM | Departure report, one per center link |
| dep_dest | input | NCM*DW | Destination of the freed slot, per link |
| dep_cls | input | NCM*CLW | Class of the freed slot, per link |
| send_valid | output | NCM | Cell dispatched on this link |
| send_port | output | NCM*PW | Local port of dispatched queue, per link |
| send_dest | output | NCM*DW | Destination of dispatched queue, per link |
| send_cls | output | NCM*CLW | Class of dispatched queue, per link |
| glb_src | input | GW | One-based global input number |
| glb_dst | input | GW | One-based global destination number |
| src_mod | output | MW | One-based input module index |
| src_loc | output | LW | One-based local port index |
| dst_mod | output | MW | One-based output module index |

## Verification
A wrong outstanding bit shows at the ports within one cycle. A bit that is lost lets a flow appear on the links a second time before its departure report. A bit that sticks leaves a flow that never leaves again after its report. A wrong slot-busy bit shows up in one of two ways. A third port's cell goes out even though both center slots for its destination and class are taken, or it stays silent after a departure. A pointer that is off by any amount shows in the combined index chosen in the first cycle after reset, and again two cycles later.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  // Flattened queue index from local port, destination and class.
  function automatic int q_index(input int port, input int dest, input int cls,
                                 input int nport, input int ncls);
    return (port * nport + dest) * ncls + cls;
  endfunction

  // Slot index within one center module: destination and class.
  function automatic int slot_index(input int dest, input int cls, input int ncls);
    return dest * ncls + cls;
  endfunction
endpackage

// File: rtl/cfd_index_calc.sv
module cfd_index_calc #(
  parameter int NLOC  = 3,
  parameter int NPORT = 6,
  localparam int GW = $clog2(NPORT + 1),
  localparam int MW = $clog2(NPORT / NLOC + 1),
  localparam int LW = $clog2(NLOC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [GW-1:0] src,
  input  logic [GW-1:0] dst,
  output logic [MW-1:0] src_mod,
  output logic [LW-1:0] src_loc,
  output logic [MW-1:0] dst_mod
);
  int s0, d0;

  always_comb begin
    s0 = (src == '0) ? 0 : int'(src) - 1;
    d0 = (dst == '0) ? 0 : int'(dst) - 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_mod <= '0;
      src_loc <= '0;
      dst_mod <= '0;
    end else begin
      src_mod <= MW'(s0 / NLOC + 1);
      src_loc <= LW'(s0 % NLOC + 1);
      dst_mod <= MW'(d0 / NLOC + 1);
    end
  end
endmodule

// File: rtl/cfd_link_pick.sv
module cfd_link_pick #(
  parameter int NLOC  = 3,
  parameter int NPORT = 6,
  parameter int NCLS  = 2,
  localparam int NQ    = NLOC * NPORT * NCLS,
  localparam int PN    = NLOC * NPORT,
  localparam int NSLOT = NPORT * NCLS,
  localparam int JW    = (PN > 1) ? $clog2(PN) : 1,
  localparam int CLW   = (NCLS > 1) ? $clog2(NCLS) : 1
) (
  input  logic [NQ-1:0]    elig,
  input  logic [NSLOT-1:0] slot_free,
  input  logic [JW-1:0]    ptr,
  output logic             hit,
  output logic [JW-1:0]    sel_j,
  output logic [CLW-1:0]   sel_c,
  output logic [NQ-1:0]    grant
);
  // Class loop outside: strict priority, rotating search within a class.
  always_comb begin
    int jj;
    int dd;
    hit   = 1'b0;
    sel_j = '0;
    sel_c = '0;
    grant = '0;
    for (int ci = NCLS - 1; ci >= 0; ci--) begin
      for (int k = 0; k < PN; k++) begin
        jj = (int'(ptr) + k) % PN;
        dd = jj % NPORT;
        if (!hit && elig[jj*NCLS+ci] && slot_free[dd*NCLS+ci]) begin
          hit   = 1'b1;
          sel_j = JW'(jj);
          sel_c = CLW'(ci);
          grant[jj*NCLS+ci] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfd_dispatcher.sv
module cfd_dispatcher
  import cfd_pkg::*;
#(
  parameter int NLOC  = 3,
  parameter int NPORT = 6,
  parameter int NCM   = 2,
  parameter int NCLS  = 2,
  localparam int NQ     = NLOC * NPORT * NCLS,
  localparam int PN     = NLOC * NPORT,
  localparam int NSLOT  = NPORT * NCLS,
  localparam int STRIDE = (PN / NCM > 0) ? PN / NCM : 1,
  localparam int PW  = (NLOC > 1) ? $clog2(NLOC) : 1,
  localparam int DW  = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int CLW = (NCLS > 1) ? $clog2(NCLS) : 1,
  localparam int JW  = (PN > 1) ? $clog2(PN) : 1,
  localparam int GW  = $clog2(NPORT + 1),
  localparam int MW  = $clog2(NPORT / NLOC + 1),
  localparam int LW  = $clog2(NLOC + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NQ-1:0]      q_occ,
  input  logic [NCM-1:0]     dep_valid,
  input  logic [NCM*DW-1:0]  dep_dest,
  input  logic [NCM*CLW-1:0] dep_cls,
  output logic [NCM-1:0]     send_valid,
  output logic [NCM*PW-1:0]  send_port,
  output logic [NCM*DW-1:0]  send_dest,
  output logic [NCM*CLW-1:0] send_cls,
  input  logic [GW-1:0]      glb_src,
  input  logic [GW-1:0]      glb_dst,
  output logic [MW-1:0]      src_mod,
  output logic [LW-1:0]      src_loc,
  output logic [MW-1:0]      dst_mod
);
  // ---------------- index arithmetic ----------------
  cfd_index_calc #(.NLOC(NLOC), .NPORT(NPORT)) u_idx (
    .clk(clk), .rst(rst), .src(glb_src), .dst(glb_dst),
    .src_mod(src_mod), .src_loc(src_loc), .dst_mod(dst_mod)
  );

  // ---------------- state ----------------
  logic [JW-1:0]    cnt_q;
  logic [NQ-1:0]    outs_q;
  logic [NSLOT-1:0] busy_q  [NCM];
  logic [PW-1:0]    owner_q [NCM][NSLOT];

  // ---------------- per-link pickers, chained ----------------
  logic [NQ-1:0]  elig_chain [NCM+1];
  logic [NQ-1:0]  grant      [NCM];
  logic           hit        [NCM];
  logic [JW-1:0]  sel_j      [NCM];
  logic [CLW-1:0] sel_c      [NCM];
  logic [JW-1:0]  ptr        [NCM];

  assign elig_chain[0] = q_occ & ~outs_q;

  for (genvar g = 0; g < NCM; g++) begin : g_link
    assign ptr[g] = JW'((int'(cnt_q) + g * STRIDE) % PN);
    cfd_link_pick #(.NLOC(NLOC), .NPORT(NPORT), .NCLS(NCLS)) u_pick (
      .elig(elig_chain[g]), .slot_free(~busy_q[g]), .ptr(ptr[g]),
      .hit(hit[g]), .sel_j(sel_j[g]), .sel_c(sel_c[g]), .grant(grant[g])
    );
    assign elig_chain[g+1] = elig_chain[g] & ~grant[g];
  end

  // ---------------- decode of picks and departures ----------------
  int pick_port [NCM];
  int pick_dest [NCM];
  int pick_slot [NCM];
  int pick_q    [NCM];
  int dep_slot  [NCM];
  int dep_q     [NCM];
  logic dep_ok  [NCM];

  always_comb begin
    for (int g = 0; g < NCM; g++) begin
      pick_port[g] = int'(sel_j[g]) / NPORT;
      pick_dest[g] = int'(sel_j[g]) % NPORT;
      pick_slot[g] = slot_index(pick_dest[g], int'(sel_c[g]), NCLS);
      pick_q[g]    = int'(sel_j[g]) * NCLS + int'(sel_c[g]);
      dep_ok[g]    = dep_valid[g] && (int'(dep_dest[g*DW +: DW]) < NPORT)
                     && (int'(dep_cls[g*CLW +: CLW]) < NCLS);
      dep_slot[g]  = dep_ok[g] ? slot_index(int'(dep_dest[g*DW +: DW]),
                                            int'(dep_cls[g*CLW +: CLW]), NCLS) : 0;
      dep_q[g]     = dep_ok[g] ? q_index(int'(owner_q[g][dep_slot[g]]),
                                         int'(dep_dest[g*DW +: DW]),
                                         int'(dep_cls[g*CLW +: CLW]), NPORT, NCLS) : 0;
    end
  end

  // ---------------- sequential update ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      outs_q     <= '0;
      send_valid <= '0;
      send_port  <= '0;
      send_dest  <= '0;
      send_cls   <= '0;
      for (int g = 0; g < NCM; g++) busy_q[g] <= '0;
    end else begin
      cnt_q <= (int'(cnt_q) == PN - 1) ? '0 : cnt_q + 1'b1;
      // departures free a busy slot and release its owner queue
      for (int g = 0; g < NCM; g++) begin
        if (dep_ok[g] && busy_q[g][dep_slot[g]]) begin
          busy_q[g][dep_slot[g]] <= 1'b0;
          outs_q[dep_q[g]]       <= 1'b0;
        end
      end
      // dispatches claim a free slot and mark their queue outstanding
      for (int g = 0; g < NCM; g++) begin
        send_valid[g]            <= hit[g];
        send_port[g*PW +: PW]    <= PW'(pick_port[g]);
        send_dest[g*DW +: DW]    <= DW'(pick_dest[g]);
        send_cls[g*CLW +: CLW]   <= sel_c[g];
        if (hit[g]) begin
          busy_q[g][pick_slot[g]]  <= 1'b1;
          owner_q[g][pick_slot[g]] <= PW'(pick_port[g]);
          outs_q[pick_q[g]]        <= 1'b1;
        end
      end
    end
  end

  // ---------------- assertions ----------------
  logic [NQ-1:0]    occ_seen;
  logic [NQ-1:0]    outs_seen;
  logic [NSLOT-1:0] busy_seen [NCM];
  int               sent_q    [NCM];
  int               sent_slot [NCM];

  always_ff @(posedge clk) begin
    occ_seen  <= q_occ;
    outs_seen <= outs_q;
    for (int g = 0; g < NCM; g++) busy_seen[g] <= busy_q[g];
  end

  always_comb begin
    for (int g = 0; g < NCM; g++) begin
      sent_slot[g] = slot_index(int'(send_dest[g*DW +: DW]) % NPORT,
                                int'(send_cls[g*CLW +: CLW]) % NCLS, NCLS);
      sent_q[g]    = (int'(send_port[g*PW +: PW]) % NLOC) * NSLOT + sent_slot[g];
    end
  end

  assert_idle_after_reset_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> send_valid == '0);

  for (genvar g = 0; g < NCM; g++) begin : g_chk
    assert_sent_was_occupied_R3: assert property (@(posedge clk) disable iff (rst)
      send_valid[g] |-> occ_seen[sent_q[g]]);
    assert_slot_was_free_R3: assert property (@(posedge clk) disable iff (rst)
      send_valid[g] |-> !busy_seen[g][sent_slot[g]]);
    assert_no_second_in_flight_R5: assert property (@(posedge clk) disable iff (rst)
      send_valid[g] |-> !outs_seen[sent_q[g]]);
    for (genvar h = g + 1; h < NCM; h++) begin : g_pair
      assert_one_link_per_queue_R4: assert property (@(posedge clk) disable iff (rst)
        (send_valid[g] && send_valid[h]) |-> sent_q[g] != sent_q[h]);
    end
  end
endmodule

// File: tb/cfd_dispatcher_tb.sv
module cfd_dispatcher_tb;
  localparam int NLOC = 3, NPORT = 6, NCM = 2, NCLS = 2;
  localparam int NQ = NLOC * NPORT * NCLS, PN = NLOC * NPORT;
  localparam int PW = 2, DW = 3, CLW = 1, GW = 3, MW = 2, LW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NQ-1:0] q_occ = '0;
  logic [NCM-1:0] dep_valid = '0;
  logic [NCM*DW-1:0] dep_dest = '0;
  logic [NCM*CLW-1:0] dep_cls = '0;
  logic [NCM-1:0] send_valid;
  logic [NCM*PW-1:0] send_port;
  logic [NCM*DW-1:0] send_dest;
  logic [NCM*CLW-1:0] send_cls;
  logic [GW-1:0] glb_src = '0, glb_dst = '0;
  logic [MW-1:0] src_mod, dst_mod;
  logic [LW-1:0] src_loc;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  cfd_dispatcher #(.NLOC(NLOC), .NPORT(NPORT), .NCM(NCM), .NCLS(NCLS)) u_dut (
    .clk(clk), .rst(rst), .q_occ(q_occ), .dep_valid(dep_valid), .dep_dest(dep_dest),
    .dep_cls(dep_cls), .send_valid(send_valid), .send_port(send_port),
    .send_dest(send_dest), .send_cls(send_cls), .glb_src(glb_src), .glb_dst(glb_dst),
    .src_mod(src_mod), .src_loc(src_loc), .dst_mod(dst_mod)
  );

  function automatic int qi(int p, int d, int c);
    return (p * NPORT + d) * NCLS + c;
  endfunction
  function automatic int f_port(int g); return int'(send_port[g*PW +: PW]); endfunction
  function automatic int f_dest(int g); return int'(send_dest[g*DW +: DW]); endfunction
  function automatic int f_cls(int g);  return int'(send_cls[g*CLW +: CLW]); endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic depart(input int g, input int d, input int c);
    dep_valid[g] = 1'b1;
    dep_dest[g*DW +: DW] = DW'(d);
    dep_cls[g*CLW +: CLW] = CLW'(c);
  endtask

  task automatic check_link(input int g, input int p, input int d, input int c, input string req);
    chk(send_valid[g], req, int'(send_valid[g]), 1);
    chk(f_port(g) == p, req, f_port(g), p);
    chk(f_dest(g) == d, req, f_dest(g), d);
    chk(f_cls(g) == c, req, f_cls(g), c);
  endtask

  // R2 and R8: idle in reset, pointer start and advance
  task automatic t_reset_and_ptr();
    int kk, j0, j1;
    repeat (3) step();
    chk(send_valid == '0, "R2 idle in reset", int'(send_valid), 0);
    rst = 1'b0;
    for (int j = 0; j < PN; j++) q_occ[j*NCLS] = 1'b1;
    step();
    q_occ = '0;
    check_link(0, 0, 0, 0, "R8 start link0");
    check_link(1, 9 / NPORT, 9 % NPORT, 0, "R8 offset link1");
    depart(0, 0, 0); depart(1, 9 % NPORT, 0);
    step();
    dep_valid = '0;
    for (int j = 0; j < PN; j++) q_occ[j*NCLS] = 1'b1;
    step();
    q_occ = '0;
    kk = 2;
    j0 = kk % PN;
    j1 = (kk + PN / NCM) % PN;
    check_link(0, j0 / NPORT, j0 % NPORT, 0, "R8 advance link0");
    check_link(1, j1 / NPORT, j1 % NPORT, 0, "R8 advance link1");
    depart(0, j0 % NPORT, 0); depart(1, j1 % NPORT, 0);
    step();
    dep_valid = '0;
    step();
  endtask

  // R1: global number to module and local indices
  task automatic t_index();
    int pairs [3][2] = '{'{4, 6}, '{3, 1}, '{6, 2}};
    for (int i = 0; i < 3; i++) begin
      glb_src = GW'(pairs[i][0]);
      glb_dst = GW'(pairs[i][1]);
      step();
      chk(int'(src_mod) == (pairs[i][0] - 1) / NLOC + 1, "R1 src module",
          int'(src_mod), (pairs[i][0] - 1) / NLOC + 1);
      chk(int'(src_loc) == (pairs[i][0] - 1) % NLOC + 1, "R1 local port",
          int'(src_loc), (pairs[i][0] - 1) % NLOC + 1);
      chk(int'(dst_mod) == (pairs[i][1] - 1) / NLOC + 1, "R1 dst module",
          int'(dst_mod), (pairs[i][1] - 1) / NLOC + 1);
    end
  endtask

  // R5: one cell of a queue in the center stage at a time
  task automatic t_order();
    q_occ[qi(0, 2, 1)] = 1'b1;
    step();
    check_link(0, 0, 2, 1, "R5 first dispatch");
    for (int i = 0; i < 3; i++) begin
      step();
      chk(send_valid == '0, "R5 held while outstanding", int'(send_valid), 0);
    end
    depart(0, 2, 1);
    step();
    dep_valid = '0;
    chk(send_valid == '0, "R5 not before report applies", int'(send_valid), 0);
    step();
    check_link(0, 0, 2, 1, "R5 resend after departure");
    q_occ = '0;
    depart(0, 2, 1);
    step();
    dep_valid = '0;
    step();
  endtask

  // R3, R4, R6: slot sharing across ports and slot-busy blocking
  task automatic t_slots();
    q_occ[qi(0, 1, 0)] = 1'b1;
    q_occ[qi(1, 1, 0)] = 1'b1;
    step();
    q_occ = '0;
    chk(send_valid == 2'b11, "R6 both links used", int'(send_valid), 3);
    chk(f_dest(0) == 1 && f_dest(1) == 1, "R6 same dest", f_dest(1), 1);
    chk(f_port(0) != f_port(1), "R4 distinct queues", f_port(1), 1 - f_port(0));
    chk(f_port(0) + f_port(1) == 1, "R6 ports 0 and 1", f_port(0) + f_port(1), 1);
    q_occ[qi(2, 1, 0)] = 1'b1;
    for (int i = 0; i < 2; i++) begin
      step();
      chk(send_valid == '0, "R3 blocked by busy slots", int'(send_valid), 0);
    end
    depart(1, 1, 0);
    step();
    dep_valid = '0;
    step();
    chk(!send_valid[0], "R3 link0 slot still busy", int'(send_valid[0]), 0);
    check_link(1, 2, 1, 0, "R3 freed slot used");
    q_occ = '0;
    depart(0, 1, 0); depart(1, 1, 0);
    step();
    dep_valid = '0;
    step();
  endtask

  // R7: class priority on link 0
  task automatic t_class();
    q_occ[qi(1, 4, 0)] = 1'b1;
    q_occ[qi(2, 5, 1)] = 1'b1;
    step();
    q_occ = '0;
    check_link(0, 2, 5, 1, "R7 high class first");
    check_link(1, 1, 4, 0, "R7 low class next link");
    depart(0, 5, 1); depart(1, 4, 0);
    step();
    dep_valid = '0;
    step();
  endtask

  // R2: reset mid-run clears outstanding state
  task automatic t_reset_mid();
    q_occ[qi(2, 3, 1)] = 1'b1;
    step();
    check_link(0, 2, 3, 1, "R2 before reset");
    rst = 1'b1;
    step();
    step();
    chk(send_valid == '0, "R2 idle during reset", int'(send_valid), 0);
    rst = 1'b0;
    step();
    check_link(0, 2, 3, 1, "R2 outstanding cleared");
    q_occ = '0;
  endtask

  initial begin
    t_reset_and_ptr();
    t_index();
    t_order();
    t_slots();
    t_class();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule